// File: doc/BRIEF.md
# Compare-Match Output Timer

This block is a 10-bit up-counter with two compare registers, called P and A. It drives one output pin from A matches. A clear-select bit picks the comparator whose match restarts the count. When P is chosen, a P value of zero lets the count run through its full range and wrap.

Each comparator has a sticky match flag. The flag is cleared by a one-cycle strobe. A 2-bit action field sets what an A match does to the internal pin state. A polarity bit can invert the pin at the port.

Software selects the operating mode, writes the compare values and starts the counter with a run bit. A pause bit freezes the count without disturbing the pin. Every rising edge of the run bit restarts the count from zero and loads the pin with a programmable initial level. Only mode code 00 is implemented. Every other mode code leaves the timer idle.

Top module: `cmp_match_timer`

## Requirements
- R1: Counting and matching happen only when `modeSel` is 2'b00. With any other code, the counter holds its value, no flag is set, and the internal pin state changes only on a `runEn` rising edge (see R7).
- R2: The counter rises by one on each active clock. A clock is active when `runEn`=1, `pauseEn`=0, the mode is 00 and no restart is happening. A match is detected on the cycle the counter equals the compare value. The clear to 0 and the flag set both appear after the following clock edge.
- R3: With `clrSel`=0, a P match clears the counter and sets `flagP`, and an A match sets `flagA`. If `cmpP` is 0, the counter runs to 0x3FF and wraps to 0, and `flagP` is set on the wrap.
- R4: With `clrSel`=1, an A match clears the counter and `flagP` is never set, even when `cmpP` is below `cmpA`.
- R5: A `cmpA` value of 0 never produces an A match: `flagA` stays clear and the pin does not change.
- R6: On an A match, `ioCtl` selects the pin action: 2'b00 keeps the state, 2'b01 drives it low, 2'b10 drives it high, and 2'b11 toggles it. Under 2'b10 the pin stays high until the next restart.
- R7: A rising edge of `runEn`, in any mode, resets the counter to 0 and loads the internal pin state with `initLvl`. Dropping `runEn` alone does not change the pin.
- R8: `pinOut` equals the internal pin state XOR `polInv`.
- R9: While `pauseEn`=1, the counter holds. When `pauseEn` returns to 0, counting resumes from the held value and the pin state is kept.
- R10: Each flag stays set until its clear strobe (`clrFlagA` or `clrFlagP`) is high at a clock edge. If a match sets the flag at that same edge, the match wins.
- R11: After reset, the counter and the internal pin state are 0 and both flags are clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| runEn | input | 1 | Run enable; its rising edge restarts the timer |
| pauseEn | input | 1 | Holds the counter while high |
| modeSel | input | 2 | Operating mode; 2'b00 is compare-match output |
| clrSel | input | 1 | Counter clear source: 0 = comparator P, 1 = comparator A |
| ioCtl | input | 2 | Pin action on an A match |
| initLvl | input | 1 | Pin state loaded on restart |
| polInv | input | 1 | Inverts the pin at the port |
| cmpP | input | 10 | Comparator P value |
| cmpA | input | 10 | Comparator A value |
| clrFlagA | input | 1 | One-cycle clear strobe for flagA |
| clrFlagP | input | 1 | One-cycle clear strobe for flagP |
| pinOut | output | 1 | Output pin level |
| flagA | output | 1 | Comparator A match flag |
| flagP | output | 1 | Comparator P match flag |

## Verification
The count itself is not visible at the ports, so a wrong counter value shows up as a shift in when matches happen. A count that is off by one, a pause that lets one clock through, or a clear source that is swapped moves a flag or a pin toggle by at least one cycle. The bench therefore samples after an exact number of edges. It places each sample where the expected and faulty timings give different flag and pin values, within one period of the compare value. A wrong pin-state register shows at once on `pinOut`, either through the toggle count after several matches or through the level right after a restart.

// File: rtl/mt_pkg.sv
package mt_pkg;

  typedef enum logic [1:0] {
    MODE_CMP    = 2'b00,
    MODE_WAVE   = 2'b01,
    MODE_PULSE  = 2'b10,
    MODE_OTHER  = 2'b11
  } mtMode_e;

  typedef enum logic [1:0] {
    ACT_KEEP = 2'b00,
    ACT_LOW  = 2'b01,
    ACT_HIGH = 2'b10,
    ACT_TOG  = 2'b11
  } mtPinAct_e;

  // Strobes from control to datapath, valid for one cycle
  typedef struct packed {
    logic restart;
    logic step;
    logic clear;
    logic setA;
    logic setP;
    logic pinSet;
    logic pinClr;
    logic pinTog;
    logic initVal;
  } mtStrobe_t;

endpackage

// File: rtl/mt_ctrl.sv
module mt_ctrl
  import mt_pkg::*;
#(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             runEn,
  input  logic             pauseEn,
  input  logic [1:0]       modeSel,
  input  logic             clrSel,
  input  logic [1:0]       ioCtl,
  input  logic             initLvl,
  input  logic [CNT_W-1:0] cmpP,
  input  logic [CNT_W-1:0] cmpA,
  input  logic [CNT_W-1:0] count,
  output mtStrobe_t        strb
);

  localparam logic [CNT_W-1:0] MAX_CNT = {CNT_W{1'b1}};

  logic runEnQ;
  logic restart;
  logic active;
  logic hitA;
  logic evtP;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) runEnQ <= 1'b0;
    else       runEnQ <= runEn;
  end

  assign restart = runEn && !runEnQ;
  assign active  = runEn && !pauseEn && (modeSel == MODE_CMP) && !restart;

  // A zero A value is unsupported and never matches
  assign hitA = active && (cmpA != '0) && (count == cmpA);
  // A zero P value means the overflow at full scale acts as the P event
  assign evtP = active && ((cmpP == '0) ? (count == MAX_CNT) : (count == cmpP));

  always_comb begin
    strb         = '0;
    strb.restart = restart;
    strb.step    = active;
    strb.clear   = clrSel ? hitA : evtP;
    strb.setA    = hitA;
    strb.setP    = evtP && !clrSel;
    strb.initVal = initLvl;
    if (hitA) begin
      unique case (mtPinAct_e'(ioCtl))
        ACT_LOW:  strb.pinClr = 1'b1;
        ACT_HIGH: strb.pinSet = 1'b1;
        ACT_TOG:  strb.pinTog = 1'b1;
        default:  ;
      endcase
    end
  end

  // R9
  pause_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (runEn && pauseEn && !restart) |=> $stable(count));

endmodule

// File: rtl/mt_dp.sv
module mt_dp
  import mt_pkg::*;
#(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  mtStrobe_t        strb,
  input  logic             clrFlagA,
  input  logic             clrFlagP,
  output logic [CNT_W-1:0] count,
  output logic             outState,
  output logic             flagA,
  output logic             flagP
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             count <= '0;
    else if (strb.restart) count <= '0;
    else if (strb.step)    count <= strb.clear ? '0 : count + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             outState <= 1'b0;
    else if (strb.restart) outState <= strb.initVal;
    else if (strb.pinSet)  outState <= 1'b1;
    else if (strb.pinClr)  outState <= 1'b0;
    else if (strb.pinTog)  outState <= !outState;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagA <= 1'b0;
      flagP <= 1'b0;
    end else begin
      if (strb.setA)    flagA <= 1'b1;
      else if (clrFlagA) flagA <= 1'b0;
      if (strb.setP)    flagP <= 1'b1;
      else if (clrFlagP) flagP <= 1'b0;
    end
  end

  // R7
  restart_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.restart |=> (count == '0) && (outState == $past(strb.initVal)));

endmodule

// File: rtl/cmp_match_timer.sv
module cmp_match_timer
  import mt_pkg::*;
#(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             runEn,
  input  logic             pauseEn,
  input  logic [1:0]       modeSel,
  input  logic             clrSel,
  input  logic [1:0]       ioCtl,
  input  logic             initLvl,
  input  logic             polInv,
  input  logic [CNT_W-1:0] cmpP,
  input  logic [CNT_W-1:0] cmpA,
  input  logic             clrFlagA,
  input  logic             clrFlagP,
  output logic             pinOut,
  output logic             flagA,
  output logic             flagP
);

  mtStrobe_t        strb;
  logic [CNT_W-1:0] count;
  logic             outState;

  mt_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .runEn   (runEn),
    .pauseEn (pauseEn),
    .modeSel (modeSel),
    .clrSel  (clrSel),
    .ioCtl   (ioCtl),
    .initLvl (initLvl),
    .cmpP    (cmpP),
    .cmpA    (cmpA),
    .count   (count),
    .strb    (strb)
  );

  mt_dp #(.CNT_W(CNT_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .clrFlagA (clrFlagA),
    .clrFlagP (clrFlagP),
    .count    (count),
    .outState (outState),
    .flagA    (flagA),
    .flagP    (flagP)
  );

  assign pinOut = outState ^ polInv;

  // R1
  idle_mode_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel != MODE_CMP) && !strb.restart |=> $stable(count) && $stable(outState));

  // R4
  no_pflag_chk: assert property (@(posedge clk) disable iff (!rstN)
    clrSel && !flagP |=> !flagP);

  // R5
  zero_a_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmpA == '0) && !flagA |=> !flagA);

endmodule

// File: tb/tb_cmp_match_timer.sv
module tb_cmp_match_timer;

  typedef struct packed {
    logic [1:0]  mode;
    logic        sel;
    logic [1:0]  io;
    logic        init;
    logic        pol;
    logic [9:0]  p;
    logic [9:0]  a;
    logic [11:0] n;
    logic        eA;
    logic        eP;
    logic        ePin;
    logic [3:0]  req;
  } vec_t;

  // Expected values are sampled after edge k+n, where edge k is the restart edge
  localparam vec_t VECS [13] = '{
    '{2'd0, 1'b0, 2'd3, 1'b0, 1'b0, 10'd5,    10'd2,    12'd3,    1'b1, 1'b0, 1'b1, 4'd6},  // R6 toggle once
    '{2'd0, 1'b0, 2'd3, 1'b0, 1'b0, 10'd5,    10'd2,    12'd6,    1'b1, 1'b1, 1'b1, 4'd3},  // R3 P match
    '{2'd0, 1'b0, 2'd3, 1'b0, 1'b0, 10'd5,    10'd2,    12'd9,    1'b1, 1'b1, 1'b0, 4'd2},  // R2 second period
    '{2'd0, 1'b0, 2'd2, 1'b0, 1'b0, 10'd5,    10'd2,    12'd9,    1'b1, 1'b1, 1'b1, 4'd6},  // R6 high stays
    '{2'd0, 1'b0, 2'd1, 1'b1, 1'b0, 10'd5,    10'd2,    12'd3,    1'b1, 1'b0, 1'b0, 4'd6},  // R6 drive low
    '{2'd0, 1'b0, 2'd0, 1'b1, 1'b0, 10'd5,    10'd2,    12'd3,    1'b1, 1'b0, 1'b1, 4'd6},  // R6 keep
    '{2'd0, 1'b0, 2'd3, 1'b0, 1'b1, 10'd5,    10'd2,    12'd3,    1'b1, 1'b0, 1'b0, 4'd8},  // R8 inverted
    '{2'd0, 1'b1, 2'd3, 1'b0, 1'b0, 10'd1,    10'd4,    12'd10,   1'b1, 1'b0, 1'b0, 4'd4},  // R4 A clears twice
    '{2'd0, 1'b1, 2'd3, 1'b0, 1'b0, 10'd1,    10'd4,    12'd5,    1'b1, 1'b0, 1'b1, 4'd4},  // R4 one match
    '{2'd0, 1'b0, 2'd3, 1'b0, 1'b0, 10'd3,    10'd0,    12'd8,    1'b0, 1'b1, 1'b0, 4'd5},  // R5 A zero
    '{2'd0, 1'b0, 2'd3, 1'b0, 1'b0, 10'd0,    10'd1000, 12'd1001, 1'b1, 1'b0, 1'b1, 4'd3},  // R3 before wrap
    '{2'd0, 1'b0, 2'd3, 1'b0, 1'b0, 10'd0,    10'd1000, 12'd1025, 1'b1, 1'b1, 1'b1, 4'd3},  // R3 wrap sets P
    '{2'd1, 1'b0, 2'd3, 1'b1, 1'b0, 10'd5,    10'd2,    12'd20,   1'b0, 1'b0, 1'b1, 4'd1}   // R1 idle mode
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic runEn = 1'b0, pauseEn = 1'b0, clrSel = 1'b0, initLvl = 1'b0, polInv = 1'b0;
  logic [1:0] modeSel = 2'd0, ioCtl = 2'd0;
  logic [9:0] cmpP = '0, cmpA = '0;
  logic clrFlagA = 1'b0, clrFlagP = 1'b0;
  logic pinOut, flagA, flagP;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  cmp_match_timer dut (
    .clk(clk), .rstN(rstN), .runEn(runEn), .pauseEn(pauseEn), .modeSel(modeSel),
    .clrSel(clrSel), .ioCtl(ioCtl), .initLvl(initLvl), .polInv(polInv),
    .cmpP(cmpP), .cmpA(cmpA), .clrFlagA(clrFlagA), .clrFlagP(clrFlagP),
    .pinOut(pinOut), .flagA(flagA), .flagP(flagP)
  );

  task automatic check(input string tag, input string what, input logic act, input logic exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0b expected %0b", tag, what, act, exp);
    end
  endtask

  task automatic startRun(input vec_t v);
    @(negedge clk);
    modeSel = v.mode; clrSel = v.sel; ioCtl = v.io; initLvl = v.init; polInv = v.pol;
    cmpP = v.p; cmpA = v.a; pauseEn = 1'b0; runEn = 1'b0;
    clrFlagA = 1'b1; clrFlagP = 1'b1;
    @(negedge clk);
    clrFlagA = 1'b0; clrFlagP = 1'b0; runEn = 1'b1;
  endtask

  task automatic stepEdges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    vec_t v;
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11", "pin", pinOut, 1'b0);
    check("R11", "flagA", flagA, 1'b0);
    check("R11", "flagP", flagP, 1'b0);
    rstN = 1'b1;
    @(negedge clk);
    polInv = 1'b1;
    #1 check("R8", "pin inverted after reset", pinOut, 1'b1);

    foreach (VECS[i]) begin
      startRun(VECS[i]);
      stepEdges(int'(VECS[i].n) + 1);
      check($sformatf("R%0d vec%0d", VECS[i].req, i), "flagA", flagA, VECS[i].eA);
      check($sformatf("R%0d vec%0d", VECS[i].req, i), "flagP", flagP, VECS[i].eP);
      check($sformatf("R%0d vec%0d", VECS[i].req, i), "pin", pinOut, VECS[i].ePin);
    end

    // R7: drop alone keeps pin, rise reloads initial level
    startRun(VECS[0]);
    stepEdges(4);
    runEn = 1'b0;
    stepEdges(1);
    check("R7", "pin after drop", pinOut, 1'b1);
    runEn = 1'b1;
    stepEdges(1);
    check("R7", "pin after rise", pinOut, 1'b0);

    // R9: pause holds count, resume keeps pin
    v = '{2'd0, 1'b0, 2'd3, 1'b0, 1'b0, 10'd0, 10'd10, 12'd0, 1'b0, 1'b0, 1'b0, 4'd9};
    startRun(v);
    stepEdges(6);
    pauseEn = 1'b1;
    stepEdges(20);
    check("R9", "flagA while paused", flagA, 1'b0);
    pauseEn = 1'b0;
    stepEdges(5);
    check("R9", "flagA before resumed match", flagA, 1'b0);
    stepEdges(1);
    check("R9", "flagA at resumed match", flagA, 1'b1);
    check("R9", "pin after resume", pinOut, 1'b1);

    // R10: match beats same-edge clear, then clear alone works
    v = '{2'd0, 1'b0, 2'd0, 1'b0, 1'b0, 10'd0, 10'd2, 12'd0, 1'b0, 1'b0, 1'b0, 4'd10};
    startRun(v);
    stepEdges(3);
    check("R10", "flagA before match", flagA, 1'b0);
    clrFlagA = 1'b1;
    stepEdges(1);
    check("R10", "match wins over clear", flagA, 1'b1);
    stepEdges(1);
    check("R10", "clear strobe", flagA, 1'b0);
    clrFlagA = 1'b0;

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule